// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects sixteen on-chip interrupt sources and one 4-bit encoded external request bus. It reduces them to a single request toward the processor, along with the priority level and the fixed exception code of the winning source. Software sets the priorities through 4-bit fields held in four 16-bit priority registers and one 32-bit extension priority register. Related sources can form a group that shares one field, and each member of a group still reports its own code.

A 32-bit mask register has no direct write. A write to one address sets mask bits, and a write to another address clears them. A separate 11-bit event-code register is available for software to read and write. Requests are level-sensitive. The three outputs are registered and follow the inputs and register contents with a latency of one clock.

Source map (index: priority field, code): 0: f0, 0x400; 1: f1, 0x420; 2: f2, 0x440; 3/4/5: f3, 0x480/0x4A0/0x4C0; 6/7/8/9: f6, 0x4E0/0x500/0x520/0x540; 10: f4, 0x560; 11/12: f5, 0x580/0x5A0; 13: x0, 0xB00; 14: x1, 0xB80; 15: x2, 0xA00. Standard field fN lives in priority register N/4. Within that register, field N%4 = 0 occupies bits 15:12, 1 occupies bits 11:8, 2 occupies bits 7:4 and 3 occupies bits 3:0. Extension field xK occupies bits 31-4K down to 28-4K of the extension register.

Top module: `irqc_top`

## Requirements
- R1: After reset, irq_req, irq_level and irq_code are 0, and every register reads back 0.
- R2: Word addresses 0 to 3 select the 16-bit priority registers. A write keeps only wr_data[15:0], and a read returns that value with zeros above it. Field placement follows the source map, with field 0 of a register in bits 15:12.
- R3: All members of a group take their priority from the group's shared field, and each member reports its own fixed code from the source map.
- R4: A write to address 5 sets every mask bit whose wr_data bit is 1. A write to address 6 clears every mask bit whose wr_data bit is 1. Zero bits leave the mask unchanged. A read at address 5 or 6 returns the mask. A source whose mask bit is 1 never wins.
- R5: A source whose priority field is 0 never requests. irq_req is 1 only when irq_level is non-zero.
- R6: The highest effective priority wins. Between internal sources of equal priority, the lower index wins. The external request wins a tie with any internal source.
- R7: When ext_lvl = v with v from 0 to 14, the external request has priority 15-v and code 0x200+0x20*v. The value 15 means no external request.
- R8: Address 7 is the event-code register. A write keeps only wr_data[10:0], and a read returns bits 31:11 as 0.
- R9: The outputs are registered. Any change on an input or in a register appears on irq_req, irq_level and irq_code at the next rising edge. With no request, all three outputs are 0.
- R10: Address 4 is the 32-bit extension priority register, and it supplies the fields for sources 13, 14 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Combinational read data |
| src_req | input | 16 | Level interrupt requests of the internal sources |
| ext_lvl | input | 4 | Encoded external request level (15 = none) |
| irq_req | output | 1 | Request to the processor |
| irq_level | output | 4 | Priority of the winning request |
| irq_code | output | 12 | Exception code of the winning request |

## Verification
Several properties are checked on every cycle: the registered outputs match the arbiter's result from one cycle earlier, an idle output carries zero level and zero code, and a raised request never has level 0. The same per-cycle checks cover mask set and clear writes taking effect, and the upper bits of the event-code register reading as zero. The scenarios are the only check that the right source wins. They cover group sharing, tie-breaking by index and against the external bus, the external level decoding, the field placement inside each priority register, and masking of a particular source.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 3;
  localparam int N_SRC       = 16;
  localparam int N_STD_REG   = 4;
  localparam int STD_REG_W   = 16;
  localparam int FIELD_W     = 4;
  localparam int FLD_PER_STD = STD_REG_W / FIELD_W;
  localparam int N_STD_FLD   = N_STD_REG * FLD_PER_STD;
  localparam int STD_IDX_W   = $clog2(N_STD_REG);
  localparam int CODE_W      = 12;
  localparam int EVT_W       = 11;
  localparam int LVL_W       = 4;
  localparam int CODE_STEP   = 'h20;
  localparam int EXT_BASE    = 'h200;
  localparam int INT_BASE    = 'h400;
  localparam int LVL_IDLE    = (1 << LVL_W) - 1;

  localparam logic [ADDR_W-1:0] A_PRIX = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(7);

  // priority field used by each source; fields >= N_STD_FLD live in the extension register
  function automatic int src_field(input int idx);
    case (idx)
      0:                 return 0;
      1:                 return 1;
      2:                 return 2;
      3, 4, 5:           return 3;
      6, 7, 8, 9:        return 6;
      10:                return 4;
      11, 12:            return 5;
      13:                return N_STD_FLD;
      14:                return N_STD_FLD + 1;
      15:                return N_STD_FLD + 2;
      default:           return 0;
    endcase
  endfunction

  // fixed exception code of each internal source
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    if (idx < 3)        return CODE_W'(INT_BASE + CODE_STEP * idx);
    else if (idx < 13)  return CODE_W'(INT_BASE + CODE_STEP * (idx + 1));
    else if (idx == 13) return CODE_W'('hB00);
    else if (idx == 14) return CODE_W'('hB80);
    else                return CODE_W'('hA00);
  endfunction

  function automatic logic [FIELD_W-1:0] field_pick(
      input logic [N_STD_REG*STD_REG_W-1:0] std_flat,
      input logic [DATA_W-1:0]              prix,
      input int                             f);
    if (f < N_STD_FLD)
      return std_flat[(f / FLD_PER_STD) * STD_REG_W
                      + STD_REG_W - FIELD_W * ((f % FLD_PER_STD) + 1) +: FIELD_W];
    else
      return prix[DATA_W - FIELD_W * (f - N_STD_FLD + 1) +: FIELD_W];
  endfunction

  // external encoded level: value LVL_IDLE yields priority 0 (no request)
  function automatic logic [LVL_W-1:0] ext_pri(input logic [LVL_W-1:0] lvl);
    return LVL_W'(LVL_IDLE) - lvl;
  endfunction

  function automatic logic [CODE_W-1:0] ext_code(input logic [LVL_W-1:0] lvl);
    return CODE_W'(EXT_BASE) + CODE_W'(CODE_STEP) * CODE_W'(lvl);
  endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [N_SRC-1:0]           src_mask,
  output logic [N_SRC*FIELD_W-1:0]   src_pri
);
  logic [STD_REG_W-1:0]           pri_q [N_STD_REG];
  logic [DATA_W-1:0]              prix_q;
  logic [DATA_W-1:0]              mask_q;
  logic [EVT_W-1:0]               evt_q;
  logic [N_STD_REG*STD_REG_W-1:0] std_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N_STD_REG; r++) pri_q[r] <= '0;
      prix_q <= '0;
      mask_q <= '0;
      evt_q  <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < N_STD_REG; r++)
        if (wr_addr == ADDR_W'(r)) pri_q[r] <= wr_data[STD_REG_W-1:0];
      if (wr_addr == A_PRIX) prix_q <= wr_data;
      if (wr_addr == A_MSET) mask_q <= mask_q | wr_data;
      if (wr_addr == A_MCLR) mask_q <= mask_q & ~wr_data;
      if (wr_addr == A_EVT)  evt_q  <= wr_data[EVT_W-1:0];
    end
  end

  for (genvar r = 0; r < N_STD_REG; r++) begin : g_flat
    assign std_flat[r*STD_REG_W +: STD_REG_W] = pri_q[r];
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_srcpri
    assign src_pri[i*FIELD_W +: FIELD_W] = field_pick(std_flat, prix_q, src_field(i));
  end

  assign src_mask = mask_q[N_SRC-1:0];

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(N_STD_REG)) begin
      rd_data[STD_REG_W-1:0] = pri_q[rd_addr[STD_IDX_W-1:0]];
    end else begin
      case (rd_addr)
        A_PRIX:         rd_data = prix_q;
        A_MSET, A_MCLR: rd_data = mask_q;
        A_EVT:          rd_data[EVT_W-1:0] = evt_q;
        default:        rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_select.sv
module irqc_select
  import irqc_pkg::*;
(
  input  logic [N_SRC-1:0]         src_req,
  input  logic [N_SRC-1:0]         src_mask,
  input  logic [N_SRC*FIELD_W-1:0] src_pri,
  input  logic [LVL_W-1:0]         ext_lvl,
  output logic                     sel_valid,
  output logic [LVL_W-1:0]         sel_pri,
  output logic [CODE_W-1:0]        sel_code
);
  logic [FIELD_W-1:0] eff  [N_SRC];
  logic [CODE_W-1:0]  ctab [N_SRC];
  logic [LVL_W-1:0]   best_pri;
  logic [CODE_W-1:0]  best_code;

  for (genvar i = 0; i < N_SRC; i++) begin : g_eff
    assign eff[i]  = (src_req[i] && !src_mask[i]) ? src_pri[i*FIELD_W +: FIELD_W] : '0;
    assign ctab[i] = src_code(i);
  end

  // external request seeds the scan so it keeps ties; strict compare keeps lower index
  always_comb begin
    best_pri  = ext_pri(ext_lvl);
    best_code = ext_code(ext_lvl);
    for (int i = 0; i < N_SRC; i++) begin
      if (LVL_W'(eff[i]) > best_pri) begin
        best_pri  = LVL_W'(eff[i]);
        best_code = ctab[i];
      end
    end
  end

  assign sel_valid = (best_pri != '0);
  assign sel_pri   = best_pri;
  assign sel_code  = sel_valid ? best_code : '0;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic [15:0]       src_req,
  input  logic [3:0]        ext_lvl,
  output logic              irq_req,
  output logic [3:0]        irq_level,
  output logic [11:0]       irq_code
);
  logic [N_SRC-1:0]         src_mask;
  logic [N_SRC*FIELD_W-1:0] src_pri;
  logic                     sel_valid;
  logic [LVL_W-1:0]         sel_pri;
  logic [CODE_W-1:0]        sel_code;

  irqc_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .src_mask (src_mask),
    .src_pri  (src_pri)
  );

  irqc_select u_sel (
    .src_req   (src_req),
    .src_mask  (src_mask),
    .src_pri   (src_pri),
    .ext_lvl   (ext_lvl),
    .sel_valid (sel_valid),
    .sel_pri   (sel_pri),
    .sel_code  (sel_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
      irq_code  <= '0;
    end else begin
      irq_req   <= sel_valid;
      irq_level <= sel_pri;
      irq_code  <= sel_code;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [31:0]       wr_data,
  input logic [2:0]        rd_addr,
  input logic [31:0]       rd_data,
  input logic              irq_req,
  input logic [3:0]        irq_level,
  input logic [11:0]       irq_code,
  input logic [N_SRC-1:0]  src_mask,
  input logic              sel_valid,
  input logic [LVL_W-1:0]  sel_pri,
  input logic [CODE_W-1:0] sel_code
);
  p_out_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> (irq_req && irq_level == $past(sel_pri) && irq_code == $past(sel_code)));

  p_out_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |=> !irq_req);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_level == '0 && irq_code == '0));

  p_req_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_level != '0);

  p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MSET) |=>
      ((src_mask & $past(wr_data[N_SRC-1:0])) == $past(wr_data[N_SRC-1:0])));

  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MCLR) |=> ((src_mask & $past(wr_data[N_SRC-1:0])) == '0));

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(src_mask));

  p_evt_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == A_EVT |-> rd_data[DATA_W-1:EVT_W] == '0);
endmodule

bind irqc_top irqc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .irq_req   (irq_req),
  .irq_level (irq_level),
  .irq_code  (irq_code),
  .src_mask  (src_mask),
  .sel_valid (sel_valid),
  .sel_pri   (sel_pri),
  .sel_code  (sel_code)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] src_req = '0;
  logic [3:0]  ext_lvl = 4'hF;
  logic        irq_req;
  logic [3:0]  irq_level;
  logic [11:0] irq_code;

  irqc_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_req(src_req), .ext_lvl(ext_lvl),
    .irq_req(irq_req), .irq_level(irq_level), .irq_code(irq_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    int        due;
    bit        req;
    bit [3:0]  lvl;
    bit [11:0] code;
    string     tag;
  } exp_t;
  exp_t sb[$];

  // bench model of the register contents
  bit [15:0] m_pri [4];
  bit [31:0] m_prix = 0;
  bit [31:0] m_mask = 0;
  int m_fld  [16] = '{0, 1, 2, 3, 3, 3, 6, 6, 6, 6, 4, 5, 5, 16, 17, 18};
  int m_code [16] = '{'h400, 'h420, 'h440, 'h480, 'h4A0, 'h4C0, 'h4E0, 'h500,
                      'h520, 'h540, 'h560, 'h580, 'h5A0, 'hB00, 'hB80, 'hA00};

  function automatic int fieldval(int f);
    if (f < 16) return (int'(m_pri[f / 4]) >> (12 - 4 * (f % 4))) & 15;
    return int'(m_prix >> (28 - 4 * (f - 16))) & 15;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 4) m_pri[a] = d[15:0];
    else if (a == 4) m_prix = d;
    else if (a == 5) m_mask = m_mask | d;
    else if (a == 6) m_mask = m_mask & ~d;
  endtask

  task automatic rd_chk(bit [2:0] a, bit [31:0] exp, string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(rd_data == exp, tag, "read", int'(rd_data), int'(exp));
  endtask

  // driver: apply a pattern and push the expected registered result
  task automatic apply(bit [15:0] s, bit [3:0] l, string tag);
    exp_t e;
    int bp, bc;
    @(negedge clk);
    src_req = s; ext_lvl = l;
    bp = 0; bc = 0;
    if (l != 4'hF) begin bp = 15 - int'(l); bc = 'h200 + 'h20 * int'(l); end
    for (int i = 0; i < 16; i++) begin
      if (s[i] && !m_mask[i] && fieldval(m_fld[i]) > bp) begin
        bp = fieldval(m_fld[i]); bc = m_code[i];
      end
    end
    e.due = cyc + 1; e.req = (bp != 0); e.lvl = 4'(bp); e.code = e.req ? 12'(bc) : 12'h0;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(irq_req == e.req, e.tag, "irq_req", int'(irq_req), int'(e.req));
      check(irq_level == e.lvl, e.tag, "irq_level", int'(irq_level), int'(e.lvl));
      check(irq_code == e.code, e.tag, "irq_code", int'(irq_code), int'(e.code));
    end
  end

  initial begin
    for (int r = 0; r < 4; r++) m_pri[r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    check(irq_req == 0 && irq_level == 0 && irq_code == 0, "R1", "outputs", int'(irq_code), 0);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'h0, "R1");
    // R5 all fields zero: nothing requests
    apply(16'hFFFF, 4'hF, "R5");
    wr(3'd0, 32'hFFFF_1234);
    rd_chk(3'd0, 32'h0000_1234, "R2");
    apply(16'h0001, 4'hF, "R2");
    apply(16'h0003, 4'hF, "R6");
    apply(16'h0010, 4'hF, "R3");
    apply(16'h0028, 4'hF, "R6");
    wr(3'd1, 32'h0000_5670);
    apply(16'h0200, 4'hF, "R3");
    apply(16'h0201, 4'hF, "R6");
    apply(16'h1C00, 4'hF, "R3");
    // R4 masking
    wr(3'd5, 32'h0000_0200);
    rd_chk(3'd5, 32'h0000_0200, "R4");
    apply(16'h0201, 4'hF, "R4");
    wr(3'd5, 32'h0000_0000);
    rd_chk(3'd6, 32'h0000_0200, "R4");
    wr(3'd6, 32'h0000_0200);
    apply(16'h0201, 4'hF, "R4");
    // R7 external levels
    apply(16'h0200, 4'h0, "R7");
    apply(16'h0000, 4'hE, "R7");
    apply(16'h0001, 4'hE, "R6");
    apply(16'h0000, 4'h7, "R7");
    apply(16'h0000, 4'hF, "R7");
    // R10 extension register
    wr(3'd4, 32'h9AB0_0000);
    rd_chk(3'd4, 32'h9AB0_0000, "R10");
    apply(16'h8000, 4'hF, "R10");
    apply(16'h6000, 4'hF, "R10");
    // R8 event code register
    wr(3'd7, 32'hFFFF_FFFF);
    rd_chk(3'd7, 32'h0000_07FF, "R8");
    // R9 one-cycle latency
    apply(16'h0000, 4'hF, "R9");
    @(negedge clk);
    src_req = 16'h0001;
    #1;
    check(irq_req == 0, "R9", "before edge", int'(irq_req), 0);
    apply(16'h0001, 4'hF, "R9");
    // R5 zero field disables after having been active
    wr(3'd0, 32'h0000_0234);
    apply(16'h0001, 4'hF, "R5");
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule